// File: doc/BRIEF.md
# Tagged Capability Memory Controller

A small on-chip memory organised as 16-byte granules, each carrying one hidden validity tag. A single request port accepts one request per cycle of one of eight kinds. Capability-width loads and stores move 128 data bits together with the tag. Integer loads and stores move 1 to 8 bytes at any byte address. Vector loads and stores move one whole granule. Two bulk operations act on a stride of consecutive granules: one reads their tags as a bit vector, and the other clears them all. Every kind of store updates the tags. A capability access that is not 16-byte aligned is refused and reported as a general-protection fault with error code zero.

Control is a response-phase state machine. The register holds which beat the previous request produces in the current cycle. `S_IDLE` means no request arrived. `S_DATA` is a load beat with data and tag. `S_TAGS` is a tag-vector beat. `S_ACK` is a store or clear completion. `S_FAULT` is a refused capability access. From any state the next state is picked only by the request presented in the current cycle. No request goes to `S_IDLE`. A misaligned capability access goes to `S_FAULT`. Kinds 0, 2 and 4 go to `S_DATA`. Kind 6 goes to `S_TAGS`. Kinds 1, 3, 5 and 7 go to `S_ACK`. The stride width is the read-only parameter `STRIDE` (default 4 granules, one 64-byte line).

Top module: `tagmem_ctrl`

## Requirements
- R1: A capability store (kind 1) writes 16 data bytes and the supplied tag to the addressed granule, so an untagged value stays untagged. A capability load (kind 0) returns the 128 data bits and that tag on the same beat, one cycle after the request.
- R2: A capability access (kind 0 or 1) with a non-zero `req_addr[3:0]` raises `fault` for exactly one cycle, in the cycle after the request, with `fault_code` = 16'h0000 and no `rsp_valid`. Data and tags are left unchanged.
- R3: An integer store (kind 3) writes `req_size`+1 bytes, taken little-endian from `req_wdata[63:0]`, starting at any byte address. It clears the tag of every granule it overlaps, including both granules when it crosses a boundary and when only one byte is written.
- R4: An integer load (kind 2) returns `req_size`+1 bytes little-endian in `rsp_data[63:0]`, with zeros in every higher bit and `rsp_tag` low.
- R5: A vector store (kind 5) writes all 16 bytes of the granule selected by `req_addr[ADDR_W-1:4]`, ignores the low four address bits and `req_wtag`, and always clears that granule's tag.
- R6: A vector load (kind 4) returns the granule's 16 data bytes with `rsp_tag` low, even when the stored tag is set. The low four address bits are ignored.
- R7: A tag read (kind 6) returns in `rsp_tags` the tags of the aligned stride holding the address. Bit i is granule (stride base + i). Address bits below the stride size are ignored. `rsp_tags` is zero on every other beat.
- R8: A tag clear (kind 7) zeroes all tags of the addressed stride in one request. It leaves data and the tags of other strides unchanged.
- R9: Every non-faulting request gives exactly one `rsp_valid` beat in the next cycle. A cycle with no request gives no beat and no fault. Store and clear beats carry zero data and a zero tag.
- R10: After reset every tag is zero, and `rsp_valid` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind, codes 0 to 7 as listed in the requirements |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Integer access length minus one |
| req_wdata | input | 128 | Store data |
| req_wtag | input | 1 | Tag written by a capability store |
| rsp_valid | output | 1 | Response beat |
| rsp_data | output | 128 | Load data |
| rsp_tag | output | 1 | Tag returned by a capability load |
| rsp_tags | output | STRIDE | Stride tag vector |
| fault | output | 1 | General-protection fault pulse |
| fault_code | output | 16 | Fault error code |

## Verification
The main function is exercised with capability stores whose tags alternate between set and clear. Each one is then reread by a capability load, a vector load and a stride tag read. This separates a tag that is stored correctly from one that only shows up on one path. Integer stores are applied as a two-byte write across a granule boundary and as a single byte inside a granule. The stride read that follows shows whether one granule or both lose their tags. Misaligned capability loads and stores sit between aligned accesses. A reload of the target granule afterwards shows that a refused store touched neither data nor tag. A tag clear is followed by reads of its own stride and of the next stride, which separates a stride-wide clear from one that spills over or clears too little.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    typedef enum logic [2:0] {
        K_CAP_LD  = 3'd0,
        K_CAP_ST  = 3'd1,
        K_INT_LD  = 3'd2,
        K_INT_ST  = 3'd3,
        K_VEC_LD  = 3'd4,
        K_VEC_ST  = 3'd5,
        K_TAG_LD  = 3'd6,
        K_TAG_CLR = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_TAGS,
        S_ACK,
        S_FAULT
    } phase_e;

    localparam int GRAN_BYTES = 16;
    localparam logic [15:0] GP_FAULT_CODE = 16'h0000;
endpackage

// File: rtl/tcm_decode.sv
module tcm_decode
    import tcm_pkg::*;
#(
    parameter int GRANULES = 16,
    parameter int STRIDE   = 4,
    parameter int ADDR_W   = $clog2(GRANULES * GRAN_BYTES),
    localparam int GIDX_W  = $clog2(GRANULES),
    localparam int SBASE_W = GIDX_W - $clog2(STRIDE)
) (
    input  logic               req_valid,
    input  kind_e              kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [2:0]         size,
    output logic               misaligned,
    output logic               commit,
    output logic [GIDX_W-1:0]  g_first,
    output logic [GIDX_W-1:0]  g_last,
    output logic [SBASE_W-1:0] s_base
);
    logic is_cap;

    always_comb begin
        is_cap     = (kind == K_CAP_LD) || (kind == K_CAP_ST);
        misaligned = req_valid && is_cap && (addr[3:0] != 4'd0);
        commit     = req_valid && !misaligned;
        g_first    = addr[ADDR_W-1:4];
        g_last     = GIDX_W'((addr + ADDR_W'(size)) >> 4);
        s_base     = addr[ADDR_W-1 -: SBASE_W];
    end
endmodule

// File: rtl/tcm_array.sv
module tcm_array
    import tcm_pkg::*;
#(
    parameter int GRANULES = 16,
    parameter int STRIDE   = 4,
    parameter int ADDR_W   = $clog2(GRANULES * GRAN_BYTES),
    localparam int NBYTES  = GRANULES * GRAN_BYTES,
    localparam int GIDX_W  = $clog2(GRANULES),
    localparam int SIDX_W  = $clog2(STRIDE),
    localparam int SBASE_W = GIDX_W - SIDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  kind_e              kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [3:0]         nbytes,
    input  logic [127:0]       wdata,
    input  logic               wtag,
    input  logic [GIDX_W-1:0]  g_first,
    input  logic [GIDX_W-1:0]  g_last,
    input  logic [SBASE_W-1:0] s_base,
    output logic [127:0]       rd_data,
    output logic               rd_tag,
    output logic [STRIDE-1:0]  rd_tags
);
    logic [7:0]          mem_q [NBYTES];
    logic [GRANULES-1:0] tags_q;

    always_ff @(posedge clk) begin
        if (we) begin
            unique case (kind)
                K_CAP_ST, K_VEC_ST: begin
                    for (int b = 0; b < GRAN_BYTES; b++)
                        mem_q[{g_first, 4'(b)}] <= wdata[8*b +: 8];
                end
                K_INT_ST: begin
                    for (int b = 0; b < 8; b++)
                        if (4'(b) < nbytes)
                            mem_q[ADDR_W'(addr + ADDR_W'(b))] <= wdata[8*b +: 8];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags_q <= '0;
        end else if (we) begin
            unique case (kind)
                K_CAP_ST: tags_q[g_first] <= wtag;
                K_VEC_ST: tags_q[g_first] <= 1'b0;
                K_INT_ST: begin
                    tags_q[g_first] <= 1'b0;
                    tags_q[g_last]  <= 1'b0;
                end
                K_TAG_CLR: begin
                    for (int s = 0; s < STRIDE; s++)
                        tags_q[{s_base, SIDX_W'(s)}] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (kind == K_INT_LD) begin
            for (int b = 0; b < 8; b++)
                if (4'(b) < nbytes)
                    rd_data[8*b +: 8] = mem_q[ADDR_W'(addr + ADDR_W'(b))];
        end else begin
            for (int b = 0; b < GRAN_BYTES; b++)
                rd_data[8*b +: 8] = mem_q[{g_first, 4'(b)}];
        end
        rd_tag = tags_q[g_first];
        for (int s = 0; s < STRIDE; s++)
            rd_tags[s] = tags_q[{s_base, SIDX_W'(s)}];
    end
endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
    import tcm_pkg::*;
#(
    parameter int GRANULES = 16,
    parameter int STRIDE   = 4,
    parameter int ADDR_W   = $clog2(GRANULES * GRAN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [127:0]      req_wdata,
    input  logic              req_wtag,
    output logic              rsp_valid,
    output logic [127:0]      rsp_data,
    output logic              rsp_tag,
    output logic [STRIDE-1:0] rsp_tags,
    output logic              fault,
    output logic [15:0]       fault_code
);
    localparam int GIDX_W  = $clog2(GRANULES);
    localparam int SBASE_W = GIDX_W - $clog2(STRIDE);

    kind_e              kind;
    logic               misaligned, commit, rd_tag;
    logic [GIDX_W-1:0]  g_first, g_last;
    logic [SBASE_W-1:0] s_base;
    logic [127:0]       rd_data, data_q;
    logic [STRIDE-1:0]  rd_tags, tags_q;
    logic               tag_q;
    phase_e             state_q, state_d;

    assign kind = kind_e'(req_kind);

    tcm_decode #(.GRANULES(GRANULES), .STRIDE(STRIDE), .ADDR_W(ADDR_W)) u_decode (
        .req_valid(req_valid), .kind(kind), .addr(req_addr), .size(req_size),
        .misaligned(misaligned), .commit(commit),
        .g_first(g_first), .g_last(g_last), .s_base(s_base)
    );

    tcm_array #(.GRANULES(GRANULES), .STRIDE(STRIDE), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(commit), .kind(kind), .addr(req_addr),
        .nbytes({1'b0, req_size} + 4'd1), .wdata(req_wdata), .wtag(req_wtag),
        .g_first(g_first), .g_last(g_last), .s_base(s_base),
        .rd_data(rd_data), .rd_tag(rd_tag), .rd_tags(rd_tags)
    );

    always_comb begin
        if (!req_valid) begin
            state_d = S_IDLE;
        end else if (misaligned) begin
            state_d = S_FAULT;
        end else begin
            unique case (kind)
                K_CAP_LD, K_INT_LD, K_VEC_LD:       state_d = S_DATA;
                K_TAG_LD:                           state_d = S_TAGS;
                K_CAP_ST, K_INT_ST, K_VEC_ST,
                K_TAG_CLR:                          state_d = S_ACK;
                default:                            state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            tag_q  <= 1'b0;
            tags_q <= '0;
        end else if (commit) begin
            data_q <= (state_d == S_DATA) ? rd_data : '0;
            tag_q  <= (kind == K_CAP_LD) && rd_tag;
            tags_q <= (state_d == S_TAGS) ? rd_tags : '0;
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_data   = '0;
        rsp_tag    = 1'b0;
        rsp_tags   = '0;
        fault      = 1'b0;
        fault_code = GP_FAULT_CODE;
        unique case (state_q)
            S_IDLE:  ;
            S_DATA:  begin rsp_valid = 1'b1; rsp_data = data_q; rsp_tag = tag_q; end
            S_TAGS:  begin rsp_valid = 1'b1; rsp_tags = tags_q; end
            S_ACK:   rsp_valid = 1'b1;
            S_FAULT: fault = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tcm_sva.sv
module tcm_sva #(
    parameter int STRIDE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_kind,
    input logic [3:0]        addr_lo,
    input logic              rsp_valid,
    input logic [63:0]       data_hi,
    input logic              rsp_tag,
    input logic [STRIDE-1:0] rsp_tags,
    input logic              fault,
    input logic [15:0]       fault_code
);
    p_misalign_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind <= 3'd1 && addr_lo != 4'd0) |=> (fault && !rsp_valid));

    p_code_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code == 16'h0000));

    p_one_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid != fault));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !fault));

    p_vec_untagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4) |=> !rsp_tag);

    p_int_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd2) |=> (data_hi == 64'd0 && !rsp_tag));

    p_tagvec_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 3'd6) |=> (rsp_tags == '0));
endmodule

bind tagmem_ctrl tcm_sva #(.STRIDE(STRIDE)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .addr_lo(req_addr[3:0]), .rsp_valid(rsp_valid), .data_hi(rsp_data[127:64]),
    .rsp_tag(rsp_tag), .rsp_tags(rsp_tags), .fault(fault), .fault_code(fault_code)
);

// File: tb/tagmem_ctrl_tb_top.sv
`timescale 1ns/1ps
module tagmem_ctrl_tb_top;
    localparam int STRIDE = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        req_size = '0;
    logic [127:0]      req_wdata = '0;
    logic              req_wtag = 1'b0;
    logic              rsp_valid, rsp_tag, fault;
    logic [127:0]      rsp_data;
    logic [STRIDE-1:0] rsp_tags;
    logic [15:0]       fault_code;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    tagmem_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_wtag(req_wtag), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .rsp_tags(rsp_tags), .fault(fault), .fault_code(fault_code)
    );

    localparam logic [127:0] D0 = {4{32'hDEADBEEF}};
    localparam logic [127:0] D1 = 128'h0F0E0D0C0B0A09080706050403020100;
    localparam logic [127:0] D2 = {4{32'h12345678}};
    localparam logic [127:0] D3 = {4{32'hCAFEF00D}};
    localparam logic [127:0] D4 = {4{32'h0BADC0DE}};
    localparam logic [127:0] D5 = {4{32'h55AA33CC}};

    typedef struct packed {
        logic [2:0]   kind;
        logic [7:0]   addr;
        logic [2:0]   size;
        logic [127:0] wdata;
        logic         wtag;
        logic         e_val;
        logic         e_flt;
        logic [127:0] e_data;
        logic         e_tag;
        logic [3:0]   e_tags;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 8'h00, 3'd0, D0, 1'b1, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd1},   // R1
        '{3'd0, 8'h00, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, D0, 1'b1, 4'b0000, 4'd1},   // R1
        '{3'd1, 8'h10, 3'd0, D1, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd1},   // R1
        '{3'd0, 8'h10, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, D1, 1'b0, 4'b0000, 4'd1},   // R1
        '{3'd1, 8'h20, 3'd0, D2, 1'b1, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd1},   // R1
        '{3'd1, 8'h30, 3'd0, D3, 1'b1, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd1},   // R1
        '{3'd6, 8'h37, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b1101, 4'd7}, // R7
        '{3'd0, 8'h08, 3'd0, 128'd0, 1'b0, 1'b0, 1'b1, 128'd0, 1'b0, 4'b0000, 4'd2}, // R2
        '{3'd1, 8'h24, 3'd0, D4, 1'b0, 1'b0, 1'b1, 128'd0, 1'b0, 4'b0000, 4'd2},   // R2
        '{3'd0, 8'h20, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, D2, 1'b1, 4'b0000, 4'd2},   // R2
        '{3'd3, 8'h2F, 3'd1, 128'hBEEF, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd3}, // R3
        '{3'd6, 8'h00, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0001, 4'd3}, // R3
        '{3'd2, 8'h2F, 3'd1, 128'd0, 1'b0, 1'b1, 1'b0, 128'hBEEF, 1'b0, 4'b0000, 4'd4}, // R4
        '{3'd1, 8'h40, 3'd0, D4, 1'b1, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd5},   // R5
        '{3'd4, 8'h4C, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, D4, 1'b0, 4'b0000, 4'd6},   // R6
        '{3'd5, 8'h45, 3'd0, D5, 1'b1, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd5},   // R5
        '{3'd0, 8'h40, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, D5, 1'b0, 4'b0000, 4'd5},   // R5
        '{3'd1, 8'h50, 3'd0, D1, 1'b1, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd8},   // R8
        '{3'd7, 8'h0A, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd8}, // R8
        '{3'd6, 8'h00, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd8}, // R8
        '{3'd6, 8'h4F, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0010, 4'd8}, // R8
        '{3'd0, 8'h00, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, D0, 1'b0, 4'b0000, 4'd8},   // R8
        '{3'd3, 8'h55, 3'd0, 128'hAA, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd3}, // R3
        '{3'd6, 8'h50, 3'd0, 128'd0, 1'b0, 1'b1, 1'b0, 128'd0, 1'b0, 4'b0000, 4'd3}, // R3
        '{3'd2, 8'h50, 3'd7, 128'd0, 1'b0, 1'b1, 1'b0, 128'h0706AA0403020100, 1'b0, 4'b0000, 4'd4} // R4
    };

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] k, input logic [7:0] a,
                         input logic [2:0] s, input logic [127:0] d, input logic t);
        @(negedge clk);
        req_valid = v; req_kind = k; req_addr = a; req_size = s;
        req_wdata = d; req_wtag = t;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [159:0] outs();
        return {9'd0, rsp_valid, fault, fault_code, rsp_data, rsp_tag, rsp_tags};
    endfunction

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [159:0] exp;
        repeat (3) @(posedge clk);
        #1;
        // R10: quiet outputs while in reset
        check(!rsp_valid && !fault, "R10", outs(), '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: tags read back zero after reset, both ends of memory
        drive(1'b1, 3'd6, 8'h00, 3'd0, '0, 1'b0);
        exp = {9'd0, 1'b1, 1'b0, 16'd0, 128'd0, 1'b0, 4'b0000};
        check(outs() == exp, "R10", outs(), exp);
        drive(1'b1, 3'd6, 8'hF0, 3'd0, '0, 1'b0);
        check(outs() == exp, "R10", outs(), exp);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].kind, VECS[i].addr, VECS[i].size, VECS[i].wdata, VECS[i].wtag);
            exp = {9'd0, VECS[i].e_val, VECS[i].e_flt, 16'd0, VECS[i].e_data,
                   VECS[i].e_tag, VECS[i].e_tags};
            check(outs() == exp, $sformatf("R%0d vec %0d", VECS[i].req, i), outs(), exp);
        end

        // R9: an idle cycle produces no beat and no fault
        drive(1'b0, 3'd0, 8'h00, 3'd0, '0, 1'b0);
        exp = '0;
        check(outs() == exp, "R9", outs(), exp);

        // R2: fault lasts one cycle only
        drive(1'b1, 3'd1, 8'h61, 3'd0, D3, 1'b1);
        check(fault && !rsp_valid && fault_code == 16'h0000, "R2", outs(), exp);
        drive(1'b0, 3'd0, 8'h00, 3'd0, '0, 1'b0);
        check(!fault && !rsp_valid, "R2", outs(), exp);
        // R2: granule 6 still tagged from the earlier store is absent; confirm it stays untagged
        drive(1'b1, 3'd6, 8'h60, 3'd0, '0, 1'b0);
        exp = {9'd0, 1'b1, 1'b0, 16'd0, 128'd0, 1'b0, 4'b0000};
        check(outs() == exp, "R2", outs(), exp);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule